// File: doc/BRIEF.md
# GPIO Level-Change Register Bank

This block gives software one 32-bit register that looks after a small group of general-purpose pins. For every pin the word holds three bits side by side: a sticky change flag, the value software wants to drive, and the level currently seen on the pin. A pin whose level moves either way, up or down, raises its change flag; the flag stays up until software writes a 1 over it. Each flag, once set, can request an interrupt if the matching per-pin enable input is high.

Pin inputs are brought into the clock domain through a two-stage synchronizer, and a change is found by comparing the synchronized level with its value one clock earlier. Pin direction and interrupt enables come in as plain inputs from elsewhere in the chip. The register port is a plain address/write-enable/data interface with no back-pressure: a write is taken on the clock edge on which `bus_wr` is high and the address matches, and read data is a combinational function of the address, so every access completes in its own cycle.

Top module: `gpio_chg_bank`

## Requirements
- R1: The register sits at address `REG_ADDR` (default 0x0C). For pin n, bit 3n is the change flag, bit 3n+1 the output value and bit 3n+2 the input level. Reads from any other address return 0 and writes to any other address change nothing.
- R2: The input bit is read-only and shows the pin level two clock edges after the pin changes; writes to it have no effect.
- R3: The output bit is read/write; `pin_out[n]` equals it while `pin_dir[n]` is 1 and is 0 otherwise, and `pin_oe` follows `pin_dir`.
- R4: A rising or a falling level change on a pin sets its change flag; the flag reads 1 three clock edges after the pin moves.
- R5: Writing 1 to a change flag clears it; writing 0 leaves it unchanged.
- R6: `irq[n]` is high exactly while the change flag of pin n is 1 and `irq_en[n]` is 1, following the enable in the same cycle.
- R7: Reset (active-low `rst_n`) forces every input, output and change bit to 0.
- R8: When a change is detected in the same cycle that software writes 1 to clear that pin's flag, the flag stays 1.
- R9: Bits from 3·PINS up to 31 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| pin_in | input | PINS | Raw pin levels |
| pin_dir | input | PINS | Direction per pin, 1 = output |
| irq_en | input | PINS | Interrupt enable per pin |
| pin_out | output | PINS | Driven pin value |
| pin_oe | output | PINS | Output enable per pin |
| irq | output | PINS | Level interrupt request per pin |

## Verification
A pin change reaches its input bit after two clock edges and its change flag and interrupt after three; a register write is visible on the edge that takes it, while reads, the direction gating of `pin_out` and the interrupt enable gating act in the same cycle. The bench drives every stimulus just after a rising edge, steps the exact number of edges each result needs, and then queues the expected word, interrupt and pin-output vectors, which a monitor compares at the following falling edge. One step is deliberately made one edge short of the flag latency to show the input bit arrives before the flag.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int FIELD_W = 3;

  function automatic int stat_pos(input int n);
    return FIELD_W * n;
  endfunction

  function automatic int out_pos(input int n);
    return FIELD_W * n + 1;
  endfunction

  function automatic int in_pos(input int n);
    return FIELD_W * n + 2;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] raw,
  output logic [PINS-1:0] lvl,
  output logic [PINS-1:0] chg
);
  logic [PINS-1:0] meta_q;
  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl = lvl_q;
  assign chg = lvl_q ^ prev_q;
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_out,
  input  logic wr_clr,
  input  logic chg,
  output logic out_q,
  output logic stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_hit) out_q <= wr_out;
      // a fresh change outranks a clear in the same cycle
      stat_q <= chg | (stat_q & ~(wr_hit & wr_clr));
    end
  end
endmodule

// File: rtl/gpio_read_pack.sv
module gpio_read_pack
  import gpio_chg_pkg::*;
#(
  parameter int PINS   = 5,
  parameter int DATA_W = 32
) (
  input  logic              sel,
  input  logic [PINS-1:0]   lvl,
  input  logic [PINS-1:0]   outv,
  input  logic [PINS-1:0]   stat,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    if (sel) begin
      for (int n = 0; n < PINS; n++) begin
        word[stat_pos(n)] = stat[n];
        word[out_pos(n)]  = outv[n];
        word[in_pos(n)]   = lvl[n];
      end
    end
  end
endmodule

// File: rtl/gpio_chg_bank.sv
module gpio_chg_bank
  import gpio_chg_pkg::*;
#(
  parameter int                PINS     = 5,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   pin_dir,
  input  logic [PINS-1:0]   irq_en,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   irq
);
  localparam int USED_W = FIELD_W * PINS;

  logic            sel;
  logic            wr_hit;
  logic [PINS-1:0] lvl;
  logic [PINS-1:0] chg;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] stat_q;
  logic            unused_wdata;

  assign sel          = (bus_addr == REG_ADDR);
  assign wr_hit       = sel & bus_wr;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:USED_W], bus_wdata[USED_W-1:0] & '0};

  gpio_in_sync #(.PINS(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pin_in),
    .lvl  (lvl),
    .chg  (chg)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    gpio_pin_slice u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(wr_hit),
      .wr_out(bus_wdata[out_pos(n)]),
      .wr_clr(bus_wdata[stat_pos(n)]),
      .chg   (chg[n]),
      .out_q (out_q[n]),
      .stat_q(stat_q[n])
    );
  end

  gpio_read_pack #(.PINS(PINS), .DATA_W(DATA_W)) u_pack (
    .sel (sel),
    .lvl (lvl),
    .outv(out_q),
    .stat(stat_q),
    .word(bus_rdata)
  );

  assign pin_oe  = pin_dir;
  assign pin_out = out_q & pin_dir;
  assign irq     = stat_q & irq_en;
endmodule

// File: rtl/gpio_chg_bank_chk.sv
module gpio_chg_bank_chk #(
  parameter int                PINS     = 5,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pin_dir,
  input logic [PINS-1:0]   irq_en,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   irq,
  input logic [PINS-1:0]   stat_q,
  input logic [PINS-1:0]   chg
);
  localparam int USED_W = 3 * PINS;

  logic hit;
  assign hit = bus_wr && (bus_addr == REG_ADDR);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:USED_W] == '0);

  p_other_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

  p_out_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_dir) == '0);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~irq_en) == '0);

  for (genvar n = 0; n < PINS; n++) begin : g_chk
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chg[n] |=> stat_q[n]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chg[n] && hit && bus_wdata[3*n]) |=> stat_q[n]);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[3*n] && !chg[n]) |=> !stat_q[n]);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg[n] && !(hit && bus_wdata[3*n])) |=> $stable(stat_q[n]));

    p_flag_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[n] && irq_en[n]) |-> irq[n]);
  end
endmodule

bind gpio_chg_bank gpio_chg_bank_chk #(
  .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_dir  (pin_dir),
  .irq_en   (irq_en),
  .pin_out  (pin_out),
  .irq      (irq),
  .stat_q   (stat_q),
  .chg      (chg)
);

// File: tb/gpio_chg_bank_test.sv
`timescale 1ns/1ps
module gpio_chg_bank_test;
  localparam logic [7:0] RA = 8'h0C;
  localparam logic [31:0] OUTS = 32'h0000_2492;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = RA;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_dir = '0;
  logic [4:0]  irq_en = '0;
  logic [4:0]  pin_out;
  logic [4:0]  pin_oe;
  logic [4:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [4:0]  irq;
    logic [4:0]  out;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  gpio_chg_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_dir(pin_dir), .irq_en(irq_en), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (bus_rdata !== it.rd || irq !== it.irq || pin_out !== it.out ||
          pin_oe !== pin_dir) begin
        bad++;
        $display("FAIL %s: rd=%h irq=%b out=%b oe=%b expected rd=%h irq=%b out=%b oe=%b",
                 it.tag, bus_rdata, irq, pin_out, pin_oe, it.rd, it.irq, it.out, pin_dir);
      end
    end
  end

  task automatic step(input int k = 1);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input string tag, input logic [31:0] rd,
                            input logic [4:0] ei, input logic [4:0] eo);
    item_t it;
    it.tag = tag; it.rd = rd; it.irq = ei; it.out = eo;
    sb.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_addr = RA; bus_wdata = '0;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: rd=%h expected run to finish", bus_rdata);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_now("R7 in reset", 32'h0, 5'b0, 5'b0);
    rst_n = 1'b1;
    step();
    expect_now("R7 after reset", 32'h0, 5'b0, 5'b0);

    pin_dir = 5'b10101;
    reg_write(RA, 32'hFFFF_FFFF);
    expect_now("R3 R9 R2 all-ones write", OUTS, 5'b0, 5'b10101);
    pin_dir = 5'b01010;
    expect_now("R3 direction gating", OUTS, 5'b0, 5'b01010);

    reg_write(8'h10, 32'h0);
    expect_now("R1 foreign write ignored", OUTS, 5'b0, 5'b01010);
    bus_addr = 8'h10;
    expect_now("R1 foreign read zero", 32'h0, 5'b0, 5'b01010);
    bus_addr = RA;

    irq_en = 5'b00100;
    pin_in = 5'b00100;
    step();
    expect_now("R2 one edge not yet", OUTS, 5'b0, 5'b01010);
    step();
    expect_now("R2 input after two edges", OUTS | 32'h100, 5'b0, 5'b01010);
    step();
    expect_now("R4 rise flag and R6 irq", OUTS | 32'h140, 5'b00100, 5'b01010);

    reg_write(RA, OUTS);
    expect_now("R5 write zero keeps flag", OUTS | 32'h140, 5'b00100, 5'b01010);
    reg_write(RA, OUTS | 32'h40);
    expect_now("R5 write one clears", OUTS | 32'h100, 5'b0, 5'b01010);

    pin_in = 5'b00000;
    step(2);
    expect_now("R2 falling input", OUTS, 5'b0, 5'b01010);
    step();
    expect_now("R4 fall flag", OUTS | 32'h40, 5'b00100, 5'b01010);
    reg_write(RA, OUTS | 32'h40);
    expect_now("R5 clear after fall", OUTS, 5'b0, 5'b01010);

    pin_in = 5'b00001;
    step(3);
    expect_now("R6 flag without enable", OUTS | 32'h5, 5'b0, 5'b01010);
    irq_en = 5'b00101;
    expect_now("R6 enable raises irq", OUTS | 32'h5, 5'b00001, 5'b01010);

    pin_in = 5'b10001;
    step(2);
    reg_write(RA, OUTS | 32'h1001);
    expect_now("R8 set wins over clear", OUTS | 32'h5004, 5'b0, 5'b01010);
    reg_write(RA, OUTS | 32'h1000);
    expect_now("R5 later clear", OUTS | 32'h4004, 5'b0, 5'b01010);

    rst_n = 1'b0;
    step();
    expect_now("R7 reset mid-run", 32'h0, 5'b0, 5'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule